// File: doc/BRIEF.md
# Delayed-Branch Program Counter Unit

This block generates the fetch address for a 32-bit processor whose instructions are all 16 bits long. Each cycle it consumes one decoded control-flow opcode for the instruction at the current fetch address. From that opcode it chooses the next fetch address. The choices are:

- step to the next halfword;
- branch relative to the PC, with a 12-bit or an 8-bit signed halfword displacement;
- branch only when the T condition flag is set, or only when it is clear;
- jump to a register value;
- call a subroutine and keep the return address in a single link register;
- return through that link register.

Every taken transfer is delayed. The instruction right after the branch is always fetched and executed first. Control reaches the target only in the cycle after that delay slot. A conditional branch that is not taken has no delay slot. A stall input freezes all state.

The link register holds one return address only. A second call replaces the first, so nested calls rely on software to save and restore the link value. Decode, instruction memory and exceptions are handled outside this block.

Top module: `flow_pc_unit`

## Requirements
- R1: While reset is applied, and until the first advancing cycle after it, the fetch PC equals the RESET_ADDR parameter (default 0x0000_1000), the slot flag is 0 and the link register is 0.
- R2: Opcode 0 (sequential) outside a delay slot advances the fetch PC by 2 and leaves the slot flag at 0.
- R3: While stall is 1, the fetch PC, the link register and the slot flag keep their values, whatever the other inputs are.
- R4: A taken transfer outside a slot does two things in the next cycle: it advances the fetch PC by 2 and raises the slot flag. In the cycle after that slot, the fetch PC equals the transfer target and the slot flag is 0.
- R5: Opcodes 1 (branch) and 5 (call) add a signed 12-bit displacement to the branch address plus 4. The displacement is in halfwords and comes from disp bits [11:0]. Opcodes 2 and 3 use only disp bits [7:0] as a signed 8-bit halfword displacement, and disp bits [11:8] have no effect.
- R6: Opcode 2 is taken only when T is 1, and opcode 3 only when T is 0. A branch that is not taken advances the PC by 2 and does not raise the slot flag.
- R7: Opcodes 4 (jump) and 6 (register call) take the register operand as the target.
- R8: Opcodes 5 and 6 write the branch address plus 4 into the link register. This is the address after the delay slot.
- R9: Opcode 7 (return) takes as its target the link register value held when the return is accepted.
- R10: Any opcode presented during a delay slot is ignored. The PC goes to the pending target, the link register is unchanged and no new slot starts.
- R11: Opcodes other than 5 and 6 never change the link register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stall_i | input | 1 | Freeze all state this cycle |
| flow_op_i | input | 3 | Decoded flow opcode of the instruction at fetch_pc_o |
| disp_i | input | DISP_W (12) | Halfword displacement field |
| reg_op_i | input | ADDR_W (32) | Register operand used as jump target |
| t_flag_i | input | 1 | Condition flag set by an earlier compare |
| fetch_pc_o | output | ADDR_W (32) | Address of the instruction being executed |
| link_o | output | ADDR_W (32) | Procedure (link) register |
| slot_o | output | 1 | Current instruction sits in a delay slot |

## Verification
The assertions assume that the opcode, displacement, register operand and T flag are valid whenever stall is low. They also assume these inputs may be arbitrary during a slot or a stall, and the design must then ignore them. The stimulus drives defined values on every input in every cycle. It deliberately places every opcode inside delay slots and under stall, so the ignore rules are exercised rather than assumed. It also fills the unused high displacement bits of short branches with junk. The displacement sweeps are exhaustive for both widths, and the register jump targets include values with the top and bottom bits set.

// File: rtl/flow_pc_pkg.sv
package flow_pc_pkg;
  typedef enum logic [2:0] {
    FL_SEQ = 3'd0,
    FL_BRA = 3'd1,
    FL_BCT = 3'd2,
    FL_BCF = 3'd3,
    FL_JMP = 3'd4,
    FL_BSR = 3'd5,
    FL_JSR = 3'd6,
    FL_RET = 3'd7
  } flow_op_e;
endpackage

// File: rtl/flow_target_calc.sv
module flow_target_calc
  import flow_pc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DISP_W  = 12,
  parameter int SHORT_W = 8
) (
  input  flow_op_e          op_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic              t_i,
  input  logic [ADDR_W-1:0] link_i,
  output logic              take_o,
  output logic              call_o,
  output logic [ADDR_W-1:0] target_o
);
  localparam int LONG_PAD  = ADDR_W - DISP_W - 1;
  localparam int SHORT_PAD = ADDR_W - SHORT_W - 1;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] long_off;
  logic [ADDR_W-1:0] short_off;

  always_comb begin
    base      = pc_i + ADDR_W'(4);
    long_off  = {{LONG_PAD{disp_i[DISP_W-1]}}, disp_i, 1'b0};
    short_off = {{SHORT_PAD{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0], 1'b0};
  end

  always_comb begin
    take_o   = 1'b0;
    call_o   = 1'b0;
    target_o = base;
    unique case (op_i)
      FL_SEQ: ;
      FL_BRA: begin take_o = 1'b1; target_o = base + long_off; end
      FL_BCT: begin take_o = t_i;  target_o = base + short_off; end
      FL_BCF: begin take_o = !t_i; target_o = base + short_off; end
      FL_JMP: begin take_o = 1'b1; target_o = reg_i; end
      FL_BSR: begin take_o = 1'b1; call_o = 1'b1; target_o = base + long_off; end
      FL_JSR: begin take_o = 1'b1; call_o = 1'b1; target_o = reg_i; end
      FL_RET: begin take_o = 1'b1; target_o = link_i; end
      default: ;
    endcase
  end

  always_comb begin
    if (op_i == FL_SEQ) assert_seq_no_take_R2: assert (!take_o && !call_o);
  end
endmodule

// File: rtl/flow_slot_ctrl.sv
module flow_slot_ctrl #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic              slot_o,
  output logic [ADDR_W-1:0] pend_o
);
  logic              slot_q, slot_n;
  logic [ADDR_W-1:0] pend_q, pend_n;

  always_comb begin
    slot_n = slot_q;
    pend_n = pend_q;
    if (slot_q) begin
      slot_n = 1'b0;
    end else if (take_i) begin
      slot_n = 1'b1;
      pend_n = target_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= 1'b0;
      pend_q <= '0;
    end else if (adv_i) begin
      slot_q <= slot_n;
      pend_q <= pend_n;
    end
  end

  assign slot_o = slot_q;
  assign pend_o = pend_q;

  assert_slot_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q && adv_i) |=> !slot_q);
endmodule

// File: rtl/flow_link_reg.sv
module flow_link_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);
  logic [ADDR_W-1:0] link_q, link_n;

  always_comb begin
    link_n = we_i ? d_i : link_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= '0;
    else        link_q <= link_n;
  end

  assign q_o = link_q;

  assert_link_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(link_q));
endmodule

// File: rtl/flow_pc_unit.sv
module flow_pc_unit
  import flow_pc_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DISP_W      = 12,
  parameter int          SHORT_W     = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] RESET_ADDR  = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic [2:0]        flow_op_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] reg_op_i,
  input  logic              t_flag_i,
  output logic [ADDR_W-1:0] fetch_pc_o,
  output logic [ADDR_W-1:0] link_o,
  output logic              slot_o
);
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] RST_PC     = ADDR_W'(RESET_ADDR);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_rst_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q[s] <= 1'b0;
        else if (s == 0) rst_sync_q[s] <= 1'b1;
        else rst_sync_q[s] <= rst_sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  flow_op_e          op;
  logic              adv;
  logic              accept;
  logic              take_raw, call_raw;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] pc_q, pc_n;
  logic [ADDR_W-1:0] link_q;
  logic [ADDR_W-1:0] pend_q;
  logic              slot_q;

  assign op     = flow_op_e'(flow_op_i);
  assign adv    = !stall_i;
  assign accept = adv && !slot_q;

  flow_target_calc #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .SHORT_W(SHORT_W)
  ) target_i (
    .op_i    (op),
    .pc_i    (pc_q),
    .disp_i  (disp_i),
    .reg_i   (reg_op_i),
    .t_i     (t_flag_i),
    .link_i  (link_q),
    .take_o  (take_raw),
    .call_o  (call_raw),
    .target_o(target)
  );

  flow_slot_ctrl #(.ADDR_W(ADDR_W)) slot_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .adv_i   (adv),
    .take_i  (take_raw),
    .target_i(target),
    .slot_o  (slot_q),
    .pend_o  (pend_q)
  );

  flow_link_reg #(.ADDR_W(ADDR_W)) link_i (
    .clk  (clk),
    .rst_n(rst_int_n),
    .we_i (accept && call_raw),
    .d_i  (pc_q + ADDR_W'(4)),
    .q_o  (link_q)
  );

  always_comb begin
    pc_n = slot_q ? pend_q : pc_q + INSN_BYTES;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  pc_q <= RST_PC;
    else if (adv)    pc_q <= pc_n;
  end

  assign fetch_pc_o = pc_q;
  assign link_o     = link_q;
  assign slot_o     = slot_q;

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    stall_i |=> ($stable(pc_q) && $stable(link_q) && $stable(slot_q)));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && op == FL_SEQ) |=> (pc_q == $past(pc_q) + INSN_BYTES && !slot_q));

  assert_slot_exit_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (slot_q && adv) |=> pc_q == $past(pend_q));

  assert_fall_through_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && (op == FL_BCT || op == FL_BCF) && !take_raw) |=> !slot_q);

  assert_call_link_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && (op == FL_BSR || op == FL_JSR)) |=> link_q == $past(pc_q) + ADDR_W'(4));

  assert_ret_target_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && op == FL_RET) |=> (slot_q && pend_q == $past(link_q)));

  assert_slot_ignore_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (slot_q && adv) |=> ($stable(link_q) && !slot_q));
endmodule

// File: tb/flow_pc_unit_tb_top.sv
module flow_pc_unit_tb_top;
  localparam logic [31:0] RST_ADDR = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall;
  logic [2:0]  op;
  logic [11:0] disp;
  logic [31:0] rg;
  logic        tf;
  logic [31:0] pc_o, link_o;
  logic        slot_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] m_pc, m_pr, m_tgt;
  logic        m_slot;

  always #2 clk = ~clk;

  flow_pc_unit #(.RESET_ADDR(RST_ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .stall_i(stall), .flow_op_i(op),
    .disp_i(disp), .reg_op_i(rg), .t_flag_i(tf),
    .fetch_pc_o(pc_o), .link_o(link_o), .slot_o(slot_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "pc", pc_o, m_pc);
    chk(req, "link", link_o, m_pr);
    chk(req, "slot", {31'd0, slot_o}, {31'd0, m_slot});
  endtask

  function automatic logic [31:0] sx12(input logic [11:0] d);
    return {{19{d[11]}}, d, 1'b0};
  endfunction
  function automatic logic [31:0] sx8(input logic [7:0] d);
    return {{23{d[7]}}, d, 1'b0};
  endfunction

  // one cycle: inputs applied at negedge, result checked at next negedge
  task automatic step(input logic [2:0] o, input logic [11:0] d, input logic [31:0] r,
                      input logic t, input logic st, input string req);
    logic        tk;
    logic [31:0] tg;
    stall = st; op = o; disp = d; rg = r; tf = t;
    if (!st) begin
      if (m_slot) begin
        m_pc = m_tgt; m_slot = 1'b0;
      end else begin
        tk = 1'b0; tg = 32'd0;
        case (o)
          3'd1: begin tk = 1'b1; tg = m_pc + 4 + sx12(d); end
          3'd2: begin tk = t;    tg = m_pc + 4 + sx8(d[7:0]); end
          3'd3: begin tk = !t;   tg = m_pc + 4 + sx8(d[7:0]); end
          3'd4: begin tk = 1'b1; tg = r; end
          3'd5: begin tk = 1'b1; tg = m_pc + 4 + sx12(d); end
          3'd6: begin tk = 1'b1; tg = r; end
          3'd7: begin tk = 1'b1; tg = m_pr; end
          default: ;
        endcase
        if (o == 3'd5 || o == 3'd6) m_pr = m_pc + 4;
        if (tk) begin m_tgt = tg; m_slot = 1'b1; end
        m_pc = m_pc + 2;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stall = 1'b1; op = 3'd0; disp = '0; rg = '0; tf = 1'b0;
    m_pc = RST_ADDR; m_pr = 32'd0; m_slot = 1'b0; m_tgt = 32'd0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1");

    // R2: sequential stepping
    for (int i = 0; i < 20; i++) step(3'd0, 12'(i * 37), 32'(i), i[0], 1'b0, "R2");

    // R3: stall with every opcode, in and out of a slot
    for (int o = 0; o < 8; o++) step(3'(o), 12'hfff, 32'hdead_beef, 1'b1, 1'b1, "R3");
    step(3'd1, 12'h010, 32'd0, 1'b0, 1'b0, "R4");
    for (int o = 0; o < 8; o++) step(3'(o), 12'h7ff, 32'h1234_5678, o[0], 1'b1, "R3");
    step(3'd0, 12'd0, 32'd0, 1'b0, 1'b0, "R4");

    // R4 R5: exhaustive 12-bit branch displacement, then slot
    for (int d = 0; d < 4096; d++) begin
      step(3'd1, 12'(d), 32'd0, d[0], 1'b0, "R5");
      step(3'd0, 12'd0, 32'd0, 1'b0, 1'b0, "R4");
    end

    // R5 R6: exhaustive 8-bit conditional, both flags, junk in bits [11:8]
    for (int o = 2; o < 4; o++)
      for (int t = 0; t < 2; t++)
        for (int d = 0; d < 256; d++) begin
          step(3'(o), {4'(d * 7 + t), 8'(d)}, 32'hffff_ffff, t[0], 1'b0, "R6");
          if (m_slot) step(3'd0, 12'd0, 32'd0, 1'b0, 1'b0, "R5");
        end

    // R7: register jumps
    for (int i = 0; i < 32; i++) begin
      step(3'd4, 12'd0, (32'h1 << i) | 32'h8000_0000, 1'b0, 1'b0, "R7");
      step(3'd0, 12'd0, 32'd0, 1'b0, 1'b0, "R7");
    end

    // R8 R9: calls, one-level link, return
    for (int i = 0; i < 64; i++) begin
      step(3'd5, 12'(i * 61 + 2048), 32'd0, 1'b0, 1'b0, "R8");
      step(3'd0, 12'd0, 32'd0, 1'b0, 1'b0, "R8");
      step(3'd0, 12'd0, 32'd0, 1'b0, 1'b0, "R11");
      step(3'd6, 12'd0, 32'h0004_0000 + 32'(i * 6), 1'b0, 1'b0, "R8");
      step(3'd0, 12'd0, 32'd0, 1'b0, 1'b0, "R8");
      step(3'd7, 12'hfff, 32'hffff_0000, 1'b1, 1'b0, "R9");
      step(3'd0, 12'd0, 32'd0, 1'b0, 1'b0, "R9");
    end

    // R10 R11: every opcode in a delay slot is ignored
    for (int o = 0; o < 8; o++) begin
      step(3'd4, 12'd0, 32'h0000_2000 + 32'(o * 16), 1'b0, 1'b0, "R11");
      step(3'(o), 12'h0ff, 32'hcafe_0000, o[1], 1'b0, "R10");
      step(3'd0, 12'd0, 32'd0, 1'b0, 1'b0, "R10");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule